// File: doc/BRIEF.md
# Periodic Event-Code Frame Source

This block runs on the event clock of a timing distribution network. It divides that clock down to the machine repetition rate. At the start of every repetition cycle it emits a heartbeat code, then plays out a programmed table of 8-bit event codes, each at a fixed clock offset from the cycle start. The result is one code slot per event clock on a byte output with a valid strobe, ready for a downstream serialiser. The block also gives a full-rate cycle tick and a half-rate tick. With an 81 MHz event clock and a divider of 1,620,000, these ticks run at 50 Hz and 25 Hz.

Beside the event stream, an 8-bit distributed bus registers eight external signals on every event clock. Event scheduling has no effect on this bus.

The sequencer is a three-state machine:
- HEART is the first slot of a cycle and emits the heartbeat.
- SCAN compares the running clock count with the offset of the current table entry.
- DONE emits null codes until the cycle ends.

The transitions are:
- HEART→SCAN when the table holds at least one entry.
- HEART→DONE when the table is empty.
- SCAN→SCAN while entries remain.
- SCAN→DONE once the last entry has been sent.
- Any state→HEART at the cycle boundary, which also rewinds the table index to entry 0.

Top module: `evg_frame_source`

## Requirements
- R1: `cycle_tick` pulses for one clock every P clocks, where P is the divider value captured at the previous cycle boundary. During reset the divider value is taken directly.
- R2: A change of `div_value` in the middle of a cycle leaves the current cycle at its old length. The new value applies from the next cycle on.
- R3: `half_tick` pulses together with the first `cycle_tick` after reset and then with every second `cycle_tick`. It never pulses on its own.
- R4: The first slot of every cycle carries the heartbeat code 0x7A with `evt_valid` high, in the same clock as `cycle_tick`.
- R5: Table entry i, holding code C and offset O (ascending order), appears on `evt_code` in slot O of the cycle, when no earlier item occupies that slot. Slot 0 is the heartbeat slot. Entry i sits at bits [i*8 +: 8] of `seq_codes` and bits [i*24 +: 24] of `seq_offsets`.
- R6: When entries collide, each later item moves to the next free slot, in index order. A collision is either equal offsets or an offset of 0 against the heartbeat.
- R7: A slot with nothing scheduled carries code 0x00 with `evt_valid` low. `evt_valid` is high exactly when `evt_code` is nonzero.
- R8: Only entries 0 to `seq_count`-1 are sent. With `seq_count` = 0, the cycle carries only the heartbeat.
- R9: An entry that has not been sent by the end of the cycle is dropped. Every cycle restarts the table at entry 0.
- R10: `dbus_out` equals `dbus_in` from one clock earlier on every clock, whatever the event activity.
- R11: While `rst_n` is low, `evt_code`, `evt_valid`, `cycle_tick`, `half_tick` and `dbus_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Event clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_value | input | 24 | Repetition period in event clocks |
| seq_count | input | 5 | Number of valid table entries (0 to 16) |
| seq_codes | input | 128 | Event codes of the table, entry i at [i*8 +: 8] |
| seq_offsets | input | 384 | Offsets from cycle start, entry i at [i*24 +: 24] |
| dbus_in | input | 8 | External distributed-bus signals |
| evt_code | output | 8 | Event code for the current slot |
| evt_valid | output | 1 | High when evt_code is nonzero |
| cycle_tick | output | 1 | Full repetition-rate tick |
| half_tick | output | 1 | Half repetition-rate tick |
| dbus_out | output | 8 | Registered distributed bus |

## Verification
The bench aims at collisions:
- Offset 0 against the heartbeat, and two entries sharing an offset. A design that dropped or overwrote the later item would lose a code, and one that did not defer would place codes one slot early.
- Entries pushed past the cycle end. A design that carried them into the next cycle, or did not rewind the index, would put stray codes in the following cycle.

It changes the divider in mid-cycle, which a design that loaded it at once would show as a shortened cycle. It checks that `seq_count` hides filled entries beyond the count, and that the half-rate tick alternates from the very first cycle.

// File: rtl/evg_pkg.sv
package evg_pkg;
    typedef enum logic [1:0] {
        S_HEART = 2'd0,
        S_SCAN  = 2'd1,
        S_DONE  = 2'd2
    } seq_state_t;

    localparam logic [7:0] CODE_HEARTBEAT = 8'h7A;
    localparam logic [7:0] CODE_NULL      = 8'h00;
endpackage

// File: rtl/evg_rate_divider.sv
module evg_rate_divider #(
    parameter int DIV_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_value,
    output logic [DIV_W-1:0] cnt,
    output logic [DIV_W-1:0] period,
    output logic             wrap
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] period_q;
    logic [DIV_W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt_q} + {{DIV_W{1'b0}}, 1'b1};
    // boundary when the next count would reach the period (period 0 wraps every clock)
    assign wrap    = cnt_inc >= {1'b0, period_q};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            period_q <= div_value;
        end else if (wrap) begin
            cnt_q    <= '0;
            period_q <= div_value;
        end else begin
            cnt_q    <= cnt_inc[DIV_W-1:0];
        end
    end

    assign cnt    = cnt_q;
    assign period = period_q;
endmodule

// File: rtl/evg_sequencer.sv
module evg_sequencer
    import evg_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int OFS_W  = 24,
    parameter int DEPTH  = 16,
    parameter int DIV_W  = 24
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [DIV_W-1:0]          cnt,
    input  logic                      wrap,
    input  logic [$clog2(DEPTH+1)-1:0] seq_count,
    input  logic [DEPTH*CODE_W-1:0]   seq_codes,
    input  logic [DEPTH*OFS_W-1:0]    seq_offsets,
    output logic [CODE_W-1:0]         slot_code,
    output logic                      slot_start
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam int CMP_W = (DIV_W > OFS_W) ? DIV_W : OFS_W;

    logic [CODE_W-1:0] code_a [DEPTH];
    logic [OFS_W-1:0]  offs_a [DEPTH];

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_unpack
            assign code_a[g] = seq_codes[g*CODE_W +: CODE_W];
            assign offs_a[g] = seq_offsets[g*OFS_W +: OFS_W];
        end
    endgenerate

    seq_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [CNT_W-1:0] count_eff;
    logic             due;
    logic             last_entry;

    assign count_eff  = (seq_count > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : seq_count;
    assign due        = CMP_W'(cnt) >= CMP_W'(offs_a[idx_q]);
    assign last_entry = CNT_W'(idx_q) == (count_eff - CNT_W'(1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            S_HEART: begin
                idx_d   = '0;
                state_d = (count_eff == '0) ? S_DONE : S_SCAN;
            end
            S_SCAN: begin
                if (due) begin
                    idx_d = idx_q + IDX_W'(1);
                    if (last_entry) state_d = S_DONE;
                end
            end
            S_DONE: begin
                state_d = S_DONE;
            end
            default: begin
                state_d = S_HEART;
            end
        endcase
        if (wrap) begin
            state_d = S_HEART;
            idx_d   = '0;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_HEART;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // slot outputs
    always_comb begin
        slot_start = 1'b0;
        slot_code  = CODE_NULL;
        unique case (state_q)
            S_HEART: begin
                slot_start = 1'b1;
                slot_code  = CODE_HEARTBEAT;
            end
            S_SCAN: begin
                if (due) slot_code = code_a[idx_q];
            end
            S_DONE: begin
                slot_code = CODE_NULL;
            end
            default: begin
                slot_code = CODE_NULL;
            end
        endcase
    end
endmodule

// File: rtl/evg_dbus_sampler.sv
module evg_dbus_sampler #(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] bus_in,
    output logic [BUS_W-1:0] bus_out
);
    always_ff @(posedge clk) begin
        if (!rst_n) bus_out <= '0;
        else        bus_out <= bus_in;
    end
endmodule

// File: rtl/evg_frame_source.sv
module evg_frame_source #(
    parameter int CODE_W = 8,
    parameter int OFS_W  = 24,
    parameter int DEPTH  = 16,
    parameter int DIV_W  = 24,
    parameter int BUS_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [DIV_W-1:0]           div_value,
    input  logic [$clog2(DEPTH+1)-1:0] seq_count,
    input  logic [DEPTH*CODE_W-1:0]    seq_codes,
    input  logic [DEPTH*OFS_W-1:0]     seq_offsets,
    input  logic [BUS_W-1:0]           dbus_in,
    output logic [CODE_W-1:0]          evt_code,
    output logic                       evt_valid,
    output logic                       cycle_tick,
    output logic                       half_tick,
    output logic [BUS_W-1:0]           dbus_out
);
    logic [DIV_W-1:0]  div_cnt;
    logic [DIV_W-1:0]  div_period;
    logic              div_wrap;
    logic [CODE_W-1:0] slot_code;
    logic              slot_start;
    logic              phase_q;

    evg_rate_divider #(.DIV_W(DIV_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_value (div_value),
        .cnt       (div_cnt),
        .period    (div_period),
        .wrap      (div_wrap)
    );

    evg_sequencer #(
        .CODE_W (CODE_W),
        .OFS_W  (OFS_W),
        .DEPTH  (DEPTH),
        .DIV_W  (DIV_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt         (div_cnt),
        .wrap        (div_wrap),
        .seq_count   (seq_count),
        .seq_codes   (seq_codes),
        .seq_offsets (seq_offsets),
        .slot_code   (slot_code),
        .slot_start  (slot_start)
    );

    evg_dbus_sampler #(.BUS_W(BUS_W)) u_dbus (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_in  (dbus_in),
        .bus_out (dbus_out)
    );

    // output slot register; half-rate phase toggles on each cycle start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_code   <= '0;
            evt_valid  <= 1'b0;
            cycle_tick <= 1'b0;
            half_tick  <= 1'b0;
            phase_q    <= 1'b0;
        end else begin
            evt_code   <= slot_code;
            evt_valid  <= slot_code != '0;
            cycle_tick <= slot_start;
            half_tick  <= slot_start & ~phase_q;
            if (slot_start) phase_q <= ~phase_q;
        end
    end
endmodule

// File: rtl/evg_frame_source_chk.sv
module evg_frame_source_chk #(
    parameter int DIV_W = 24,
    parameter int BUS_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       evt_code,
    input logic             evt_valid,
    input logic             cycle_tick,
    input logic             half_tick,
    input logic [BUS_W-1:0] dbus_in,
    input logic [BUS_W-1:0] dbus_out,
    input logic             wrap,
    input logic [DIV_W-1:0] period_q
);
    logic last_half_q;

    always_ff @(posedge clk) begin
        if (!rst_n)          last_half_q <= 1'b0;
        else if (cycle_tick) last_half_q <= half_tick;
    end

    assert_heartbeat_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_tick |-> (evt_code == 8'h7A && evt_valid));

    assert_half_inside_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        half_tick |-> cycle_tick);

    assert_half_alternates_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_tick && last_half_q) |-> !half_tick);

    assert_period_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(period_q));

    assert_dbus_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (dbus_out == $past(dbus_in)));
endmodule

bind evg_frame_source evg_frame_source_chk #(.DIV_W(DIV_W), .BUS_W(BUS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_code   (evt_code),
    .evt_valid  (evt_valid),
    .cycle_tick (cycle_tick),
    .half_tick  (half_tick),
    .dbus_in    (dbus_in),
    .dbus_out   (dbus_out),
    .wrap       (div_wrap),
    .period_q   (div_period)
);

// File: tb/tb_evg_frame_source.sv
module tb_evg_frame_source;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [23:0]       div_value = 24'd20;
    logic [4:0]        seq_count = '0;
    logic [DEPTH*8-1:0]  seq_codes = '0;
    logic [DEPTH*24-1:0] seq_offsets = '0;
    logic [7:0]        dbus_in = '0;
    logic [7:0]        evt_code;
    logic              evt_valid;
    logic              cycle_tick;
    logic              half_tick;
    logic [7:0]        dbus_out;

    int checks = 0;
    int fails  = 0;
    int exp_cyc [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    evg_frame_source dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .div_value   (div_value),
        .seq_count   (seq_count),
        .seq_codes   (seq_codes),
        .seq_offsets (seq_offsets),
        .dbus_in     (dbus_in),
        .evt_code    (evt_code),
        .evt_valid   (evt_valid),
        .cycle_tick  (cycle_tick),
        .half_tick   (half_tick),
        .dbus_out    (dbus_out)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clear_table();
        seq_codes   = '0;
        seq_offsets = '0;
    endtask

    task automatic set_entry(int i, int code, int ofs);
        seq_codes[i*8 +: 8]    = code[7:0];
        seq_offsets[i*24 +: 24] = ofs[23:0];
    endtask

    // expected slot contents of one cycle, built from the requirement text
    task automatic build_expected(int period, int count);
        int free_slot;
        for (int k = 0; k < 64; k++) exp_cyc[k] = 0;
        exp_cyc[0] = 8'h7A;
        free_slot = 1;
        for (int i = 0; i < count; i++) begin
            int ofs = int'(seq_offsets[i*24 +: 24]);
            int s = (ofs > free_slot) ? ofs : free_slot;
            if (s < period) begin
                exp_cyc[s] = int'(seq_codes[i*8 +: 8]);
                free_slot = s + 1;
            end else begin
                free_slot = period;
            end
        end
    endtask

    // leaves the clock at a negedge with rst_n just released; the next negedge shows slot 0
    task automatic do_reset(int period, int count);
        @(negedge clk);
        rst_n = 1'b0;
        div_value = period[23:0];
        seq_count = count[4:0];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_frames(string tag, int period, int count, int nslots);
        do_reset(period, count);
        build_expected(period, count);
        for (int k = 0; k < nslots; k++) begin
            @(posedge clk);
            @(negedge clk);
            check({tag, " code"}, int'(evt_code), exp_cyc[k % period]);
            check("R7 valid", int'(evt_valid), (exp_cyc[k % period] != 0) ? 1 : 0);
            check("R1 cycle_tick", int'(cycle_tick), (k % period == 0) ? 1 : 0);
            check("R3 half_tick", int'(half_tick), (k % (2*period) == 0) ? 1 : 0);
        end
    endtask

    task automatic test_reset();
        clear_table();
        dbus_in = 8'hA5;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 evt_code in reset", int'(evt_code), 0);
        check("R11 evt_valid in reset", int'(evt_valid), 0);
        check("R11 cycle_tick in reset", int'(cycle_tick), 0);
        check("R11 half_tick in reset", int'(half_tick), 0);
        check("R11 dbus_out in reset", int'(dbus_out), 0);
        dbus_in = 8'h00;
    endtask

    task automatic test_basic();
        clear_table();
        set_entry(0, 8'h11, 3);
        set_entry(1, 8'h22, 7);
        set_entry(2, 8'h33, 15);
        run_frames("R4/R5 basic", 20, 3, 40);
    endtask

    task automatic test_collide();
        clear_table();
        set_entry(0, 8'h41, 0);
        set_entry(1, 8'h42, 0);
        set_entry(2, 8'h43, 5);
        set_entry(3, 8'h44, 5);
        set_entry(4, 8'h45, 6);
        build_expected(12, 5);
        check("R6 deferred slot 2", exp_cyc[2], 8'h42);
        run_frames("R6 collide", 12, 5, 36);
    endtask

    task automatic test_drop();
        clear_table();
        set_entry(0, 8'h51, 6);
        set_entry(1, 8'h52, 6);
        set_entry(2, 8'h53, 7);
        set_entry(3, 8'h54, 7);
        run_frames("R9 drop", 8, 4, 32);
    endtask

    task automatic test_count();
        clear_table();
        set_entry(0, 8'h61, 2);
        set_entry(1, 8'h62, 4);
        set_entry(2, 8'h63, 6);
        set_entry(3, 8'h64, 8);
        run_frames("R8 count0", 10, 0, 20);
        run_frames("R8 count2", 10, 2, 20);
    endtask

    task automatic test_div_change();
        clear_table();
        do_reset(10, 0);
        for (int k = 0; k < 26; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k == 3) div_value = 24'd6;
            check("R2 cycle_tick after divider change", int'(cycle_tick),
                  (k == 0 || k == 10 || k == 16 || k == 22) ? 1 : 0);
            check("R4 heartbeat after divider change", int'(evt_code),
                  (k == 0 || k == 10 || k == 16 || k == 22) ? 8'h7A : 0);
        end
    endtask

    task automatic test_dbus();
        logic [7:0] prev;
        clear_table();
        set_entry(0, 8'h71, 1);
        set_entry(1, 8'h72, 2);
        do_reset(5, 2);
        prev = 8'h3C;
        dbus_in = prev;
        for (int i = 0; i < 30; i++) begin
            @(posedge clk);
            @(negedge clk);
            check("R10 dbus_out", int'(dbus_out), int'(prev));
            prev = 8'(i * 37 + 5);
            dbus_in = prev;
        end
    endtask

    initial begin
        test_reset();
        test_basic();
        test_collide();
        test_drop();
        test_count();
        test_div_change();
        test_dbus();
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule